// File: doc/BRIEF.md
# Three-Slot Voice Recorder Controller

This block is the control core of a small digital voice recorder. It keeps three separate recording slots in internal storage. One slot is selected at a time. A slot-advance button steps the selection, wrapping after the third slot. A record button fills the selected slot with audio samples, one per sample strobe, until the slot is full. A play button replays the selected slot, one sample per strobe, up to its last recorded sample.

Incoming 16-bit samples are packed in pairs into 32-bit storage words and unpacked again on playback. All three buttons pass through debouncers. The single status LED is steady on while recording, blinks during playback, and is off otherwise.

An auto-trigger mode makes the record button only arm the recorder. Capture then begins with the first sample whose magnitude exceeds a programmable threshold. The slot capacity is a parameter: a full-length build uses 5600 samples per slot, and the default is kept smaller so the storage stays compact. The nominal strobe rate is 5512 per second; the block itself only counts strobes.

Top module: `voice_rec_ctrl`

## Requirements
- R1: After reset the LED is off, `slot_idx` is 0 (slot 1 is selected) and `smp_out` is 0.
- R2: A debounced slot-advance press in idle moves `slot_idx` through 0, 1, 2, 0 in turn. Here 0, 1 and 2 stand for slots 1, 2 and 3.
- R3: With `auto_en` low, a debounced record press in idle starts recording into the selected slot, and the LED stays steadily on for the whole recording.
- R4: While recording, each strobe stores `smp_in`. After `SLOT_SAMPLES` strobes the recording ends by itself and the LED turns off.
- R5: A debounced play press starts playback of the selected slot. On each strobe `smp_out` presents the next stored sample, in recording order, and holds that value until the next playback strobe. After the last recorded sample the block returns to idle and the LED is off.
- R6: During playback the LED alternates on and off, and each level lasts exactly `BLINK_HALF` clock cycles.
- R7: Sample 2k of a slot is stored in bits 31:16 of storage word k and sample 2k+1 in bits 15:0. Playback unpacks them in that order.
- R8: With `auto_en` high, a record press only arms the recorder, and the LED stays off while armed. Recording starts at the first strobe whose two's-complement magnitude is strictly greater than `level_thr`; -32768 counts as magnitude 32768. That sample becomes the first one recorded.
- R9: A play press on a slot that has never been recorded starts no playback. The LED stays off and `smp_out` does not change.
- R10: While armed, recording or playing, presses of any button are ignored: the slot does not change and the recording or playback in progress continues.
- R11: A button level that lasts fewer than `DEB_CYCLES` consecutive clocks is not a press. A level that stays stable for `DEB_CYCLES` clocks is.
- R12: Each slot keeps its own data and its own length, so recording one slot leaves the playback of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_btn | input | 1 | Record pushbutton, raw level |
| play_btn | input | 1 | Play pushbutton, raw level |
| next_btn | input | 1 | Slot-advance pushbutton, raw level |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_in | input | SAMPLE_W | Signed audio sample to record |
| auto_en | input | 1 | Level-triggered recording enable |
| level_thr | input | SAMPLE_W | Unsigned magnitude threshold for auto trigger |
| smp_out | output | SAMPLE_W | Playback sample |
| led | output | 1 | Status LED |
| slot_idx | output | 2 | Selected slot, 0 to 2 |

## Verification
The recorded data is tried with several patterns:
- a ramp, which exposes a wrong order or a wrong word address;
- alternating signs, which exposes sign loss in the unpacking;
- walking ones, which exposes swapped or merged halves.

In auto mode, the bench sends samples whose magnitude sits just below and exactly at the threshold, which must not trigger, and then one just above it, which must. It also sends the most negative value against the largest threshold, which separates a strictly-greater comparison on a 17-bit magnitude from a 16-bit one. Button glitches one clock shorter than the debounce window, and presses made during every busy state, show whether inputs are wrongly accepted. Interleaved recordings across all three slots show whether slots are kept independent.

// File: rtl/vrc_pkg.sv
// Shared types for the voice recorder controller.
// Assumes exactly three slots; the slot index is two bits wide.
package vrc_pkg;
    localparam int NSLOTS = 3;
    localparam int SLOT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_REC  = 3'd2,
        ST_PLAY = 3'd3,
        ST_SKIP = 3'd4
    } state_t;
endpackage

// File: rtl/vrc_debounce.sv
// Button debouncer: a two-flop synchronizer followed by a stability counter.
// A new level is accepted after DEB_CYCLES consecutive clocks; an accepted
// rising level gives a one-cycle press pulse. Assumes DEB_CYCLES >= 2.
module vrc_debounce #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    localparam int CNT_W = $clog2(DEB_CYCLES + 1);

    logic [1:0]       sync_q;
    logic             stable_q;
    logic [CNT_W-1:0] cnt_q;

    // Bring the raw level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], btn_raw};
    end

    // Count how long the level has differed from the accepted one, and emit the press pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            cnt_q    <= '0;
            press    <= 1'b0;
        end else begin
            press <= 1'b0;
            if (sync_q[1] != stable_q) begin
                if (cnt_q == CNT_W'(DEB_CYCLES - 1)) begin
                    stable_q <= sync_q[1];
                    cnt_q    <= '0;
                    press    <= sync_q[1];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/vrc_blink.sv
// Blink phase generator. While inactive, the phase rests at 1 and the counter
// is cleared, so every activation starts with a full "on" half period of
// BLINK_HALF clocks. Assumes BLINK_HALF >= 1.
module vrc_blink #(
    parameter int BLINK_HALF = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic phase
);
    localparam int CNT_W = $clog2(BLINK_HALF + 1);

    logic [CNT_W-1:0] cnt_q;

    // Toggle the phase after every BLINK_HALF active cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
            phase <= 1'b1;
        end else if (cnt_q == CNT_W'(BLINK_HALF - 1)) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vrc_store.sv
// Packed sample storage: one register bank per slot, each WORDS words deep.
// There is one write port and one combinational read port. Storage is not
// reset; the controller never reads a word before writing it.
module vrc_store #(
    parameter int NSLOTS = 3,
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    parameter int SLOT_W = 2,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] bank_q [NSLOTS];

    for (genvar s = 0; s < NSLOTS; s++) begin : g_bank
        logic [WORD_W-1:0] mem [WORDS];

        // Write the addressed word of this bank.
        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == SLOT_W'(s)) mem[wr_addr] <= wr_data;
        end

        assign bank_q[s] = mem[rd_addr];
    end

    // Select the bank of the slot being read.
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NSLOTS; s++) begin
            if (rd_slot == SLOT_W'(s)) rd_data = bank_q[s];
        end
    end
endmodule

// File: rtl/voice_rec_ctrl.sv
// Three-slot voice recorder controller.
// It records strobed samples into the selected slot, packing two samples per
// storage word (the even-index sample in the upper half), and plays a slot
// back up to its recorded length. It drives a steady LED while recording and
// a blinking LED while playing.
// Assumes SLOT_SAMPLES is even and at least 4, and that smp_stb is a
// single-cycle pulse.
module voice_rec_ctrl #(
    parameter int SAMPLE_W     = 16,
    parameter int SLOT_SAMPLES = 256,
    parameter int DEB_CYCLES   = 16,
    parameter int BLINK_HALF   = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_btn,
    input  logic                play_btn,
    input  logic                next_btn,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_in,
    input  logic                auto_en,
    input  logic [SAMPLE_W-1:0] level_thr,
    output logic [SAMPLE_W-1:0] smp_out,
    output logic                led,
    output logic [1:0]          slot_idx
);
    import vrc_pkg::*;

    localparam int WORDS  = SLOT_SAMPLES / 2;
    localparam int WORD_W = 2 * SAMPLE_W;
    localparam int ADDR_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SLOT_SAMPLES + 1);
    localparam int NBTN   = 3;

    state_t              state;
    logic [SLOT_W-1:0]   slot;
    logic [IDX_W-1:0]    idx;
    logic [SAMPLE_W-1:0] hold_q;
    logic [IDX_W-1:0]    slot_len [NSLOTS];

    logic [NBTN-1:0]     raw_btn;
    logic [NBTN-1:0]     press;
    logic                rec_p, play_p, next_p;
    logic                blink_ph;
    logic                over_thr;
    logic [SAMPLE_W:0]   magnitude;
    logic                wr_en;
    logic [ADDR_W-1:0]   word_addr;
    logic [WORD_W-1:0]   rd_word;

    assign raw_btn = {next_btn, play_btn, rec_btn};

    for (genvar b = 0; b < NBTN; b++) begin : g_deb
        vrc_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
            .clk    (clk),
            .rst_n  (rst_n),
            .btn_raw(raw_btn[b]),
            .press  (press[b])
        );
    end

    assign rec_p  = press[0];
    assign play_p = press[1];
    assign next_p = press[2];

    // Two's-complement magnitude on one extra bit, so the most negative value counts as 2^(W-1).
    always_comb begin
        if (smp_in[SAMPLE_W-1]) magnitude = {1'b0, ~smp_in} + 1'b1;
        else                    magnitude = {1'b0, smp_in};
        over_thr = magnitude > {1'b0, level_thr};
    end

    assign word_addr = ADDR_W'(idx >> 1);
    assign wr_en     = (state == ST_REC) && smp_stb && idx[0];

    vrc_store #(
        .NSLOTS(NSLOTS),
        .WORDS (WORDS),
        .WORD_W(WORD_W),
        .SLOT_W(SLOT_W),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_slot(slot),
        .wr_addr(word_addr),
        .wr_data({hold_q, smp_in}),
        .rd_slot(slot),
        .rd_addr(word_addr),
        .rd_data(rd_word)
    );

    vrc_blink #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .active(state == ST_PLAY),
        .phase (blink_ph)
    );

    // Main sequencer: slot selection, record, arm and playback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            slot    <= '0;
            idx     <= '0;
            hold_q  <= '0;
            smp_out <= '0;
            for (int s = 0; s < NSLOTS; s++) slot_len[s] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (rec_p) begin
                        state <= auto_en ? ST_ARM : ST_REC;
                    end else if (play_p) begin
                        if (slot_len[slot] != '0) state <= ST_PLAY;
                    end else if (next_p) begin
                        state <= ST_SKIP;
                    end
                end
                ST_SKIP: begin
                    slot  <= (slot == SLOT_W'(NSLOTS - 1)) ? '0 : slot + 1'b1;
                    state <= ST_IDLE;
                end
                ST_ARM: begin
                    if (smp_stb && over_thr) begin
                        hold_q <= smp_in;
                        idx    <= IDX_W'(1);
                        state  <= ST_REC;
                    end
                end
                ST_REC: begin
                    if (smp_stb) begin
                        if (!idx[0]) hold_q <= smp_in;
                        idx <= idx + 1'b1;
                        if (idx == IDX_W'(SLOT_SAMPLES - 1)) begin
                            slot_len[slot] <= IDX_W'(SLOT_SAMPLES);
                            state          <= ST_IDLE;
                        end
                    end
                end
                ST_PLAY: begin
                    if (smp_stb) begin
                        smp_out <= idx[0] ? rd_word[SAMPLE_W-1:0] : rd_word[WORD_W-1:SAMPLE_W];
                        idx     <= idx + 1'b1;
                        if (idx == slot_len[slot] - 1'b1) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign led      = (state == ST_REC) || ((state == ST_PLAY) && blink_ph);
    assign slot_idx = slot;
endmodule

// File: rtl/vrc_check.sv
// Protocol checker for the voice recorder controller, bound to the top module.
module vrc_check #(
    parameter int SAMPLE_W     = 16,
    parameter int IDX_W        = 9,
    parameter int SLOT_SAMPLES = 256
) (
    input logic                clk,
    input logic                rst_n,
    input vrc_pkg::state_t     state,
    input logic [1:0]          slot_idx,
    input logic                led,
    input logic                smp_stb,
    input logic [SAMPLE_W-1:0] smp_out,
    input logic [IDX_W-1:0]    idx
);
    import vrc_pkg::*;

    // R2: the selection only moves through the skip state.
    p_slot_only_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slot_idx) |-> $past(state) == ST_SKIP);

    // R2: the skip state steps the selection with wrap-around.
    p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SKIP |=> slot_idx == (($past(slot_idx) == 2'd2) ? 2'd0 : $past(slot_idx) + 2'd1));

    // R3: the LED is on throughout recording.
    p_led_rec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_REC |-> led);

    // R8: the LED is dark when armed, idle or skipping.
    p_led_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ARM || state == ST_SKIP) |-> !led);

    // R4: a strobe on the last sample position ends the recording.
    p_rec_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REC && smp_stb && idx == IDX_W'(SLOT_SAMPLES - 1)) |=> state == ST_IDLE);

    // R5: the playback output moves only on a playback strobe.
    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_PLAY && smp_stb) |=> $stable(smp_out));
endmodule

bind voice_rec_ctrl vrc_check #(
    .SAMPLE_W    (SAMPLE_W),
    .IDX_W       (IDX_W),
    .SLOT_SAMPLES(SLOT_SAMPLES)
) u_vrc_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .slot_idx(slot_idx),
    .led     (led),
    .smp_stb (smp_stb),
    .smp_out (smp_out),
    .idx     (idx)
);

// File: tb/test_voice_rec_ctrl.sv
module test_voice_rec_ctrl;
    localparam int CAP  = 8;
    localparam int DEB  = 3;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_btn = 1'b0, play_btn = 1'b0, next_btn = 1'b0;
    logic        smp_stb = 1'b0;
    logic [15:0] smp_in = '0;
    logic        auto_en = 1'b0;
    logic [15:0] level_thr = '0;
    logic [15:0] smp_out;
    logic        led;
    logic [1:0]  slot_idx;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] exp_data [3][CAP];

    always #5 clk = ~clk;

    voice_rec_ctrl #(
        .SAMPLE_W(16), .SLOT_SAMPLES(CAP), .DEB_CYCLES(DEB), .BLINK_HALF(HALF)
    ) i_voice_rec_ctrl (
        .clk(clk), .rst_n(rst_n), .rec_btn(rec_btn), .play_btn(play_btn),
        .next_btn(next_btn), .smp_stb(smp_stb), .smp_in(smp_in), .auto_en(auto_en),
        .level_thr(level_thr), .smp_out(smp_out), .led(led), .slot_idx(slot_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // 0 = record, 1 = play, 2 = next
    task automatic press(input int which);
        @(negedge clk);
        case (which)
            0: rec_btn = 1'b1;
            1: play_btn = 1'b1;
            default: next_btn = 1'b1;
        endcase
        repeat (DEB + 6) @(negedge clk);
        rec_btn = 1'b0; play_btn = 1'b0; next_btn = 1'b0;
        repeat (DEB + 6) @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] v);
        @(negedge clk);
        smp_stb = 1'b1;
        smp_in = v;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    function automatic logic [15:0] pattern(input int p, input int i);
        case (p)
            0: pattern = 16'(i * 16'h0101 + 16'h0010);
            1: pattern = (i % 2 == 0) ? 16'(16'h8000 + i) : 16'(16'h7FF0 - i);
            default: pattern = 16'(16'h0001 << (i * 2 + p));
        endcase
    endfunction

    // Manual recording of slot s with pattern p; presses during recording are ignored (R10).
    task automatic record_manual(input int s, input int p);
        auto_en = 1'b0;
        press(0);
        check(led == 1'b1, "R3 led on at record start", led, 1);
        for (int i = 0; i < CAP; i++) begin
            exp_data[s][i] = pattern(p, i);
            strobe(exp_data[s][i]);
            if (i == 2) begin
                press(2);
                press(1);
                check(slot_idx == 2'(s), "R10 slot kept during record", slot_idx, s);
            end
            if (i < CAP - 1) check(led == 1'b1, "R3 led steady while recording", led, 1);
        end
        @(negedge clk);
        check(led == 1'b0, "R4 led off after slot full", led, 0);
        check(slot_idx == 2'(s), "R10 slot unchanged after record", slot_idx, s);
    endtask

    // Playback of slot s, checking blink timing (R6), data order (R5, R7) and the ignored record press (R10).
    task automatic play_check(input int s, input bit poke);
        int prev, last_t, trans;
        press(1);
        prev = led; last_t = 0; trans = 0;
        for (int k = 0; k < 6 * HALF; k++) begin
            @(negedge clk);
            if (led != prev[0]) begin
                if (trans > 0) check(k - last_t == HALF, "R6 blink half period", k - last_t, HALF);
                last_t = k;
                trans++;
                prev = led;
            end
        end
        check(trans >= 3, "R6 led toggles during playback", trans, 3);
        for (int i = 0; i < CAP; i++) begin
            strobe(16'hDEAD);
            check(smp_out == exp_data[s][i], "R5 R7 playback sample", smp_out, exp_data[s][i]);
            if (poke && i == 1) begin
                press(0);
                check(smp_out == exp_data[s][i], "R5 output held between strobes", smp_out, exp_data[s][i]);
            end
        end
        repeat (2 * HALF + 2) @(negedge clk);
        check(led == 1'b0, "R5 led off after playback", led, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(led == 1'b0, "R1 led after reset", led, 0);
        check(slot_idx == 2'd0, "R1 slot after reset", slot_idx, 0);
        check(smp_out == 16'd0, "R1 sample out after reset", smp_out, 0);

        // R11: a glitch one clock shorter than the window is no press.
        @(negedge clk); rec_btn = 1'b1;
        repeat (DEB - 1) @(negedge clk);
        rec_btn = 1'b0;
        repeat (12) @(negedge clk);
        check(led == 1'b0, "R11 short record glitch ignored", led, 0);
        @(negedge clk); next_btn = 1'b1;
        repeat (DEB - 1) @(negedge clk);
        next_btn = 1'b0;
        repeat (12) @(negedge clk);
        check(slot_idx == 2'd0, "R11 short advance glitch ignored", slot_idx, 0);

        // R9: playing an empty slot does nothing.
        press(1);
        for (int k = 0; k < 3 * HALF; k++) begin
            @(negedge clk);
            if (led) check(1'b0, "R9 empty slot led", led, 0);
        end
        strobe(16'h1234);
        check(smp_out == 16'd0, "R9 empty slot output unchanged", smp_out, 0);

        // Sweep three data patterns through slot 1.
        for (int p = 0; p < 3; p++) begin
            record_manual(0, p);
            play_check(0, p == 0);
        end
        // R10: the record press during playback did not overwrite the slot.
        play_check(0, 1'b0);

        // Slot 2 in auto mode: threshold edge cases (R8).
        press(2);
        check(slot_idx == 2'd1, "R2 advance to slot 2", slot_idx, 1);
        auto_en = 1'b1;
        level_thr = 16'd1000;
        press(0);
        check(led == 1'b0, "R8 led off while armed", led, 0);
        press(2);
        check(slot_idx == 2'd1, "R10 advance ignored while armed", slot_idx, 1);
        strobe(16'd500);
        check(led == 1'b0, "R8 below threshold", led, 0);
        strobe(-16'sd1000);
        check(led == 1'b0, "R8 equal magnitude does not trigger", led, 0);
        strobe(16'd1000);
        check(led == 1'b0, "R8 equal positive does not trigger", led, 0);
        exp_data[1][0] = -16'sd1001;
        strobe(exp_data[1][0]);
        check(led == 1'b1, "R8 trigger above threshold", led, 1);
        for (int i = 1; i < CAP; i++) begin
            exp_data[1][i] = 16'(i * 3 - 7);
            strobe(exp_data[1][i]);
        end
        @(negedge clk);
        check(led == 1'b0, "R4 auto recording ends", led, 0);
        auto_en = 1'b0;
        play_check(1, 1'b0);

        // Slot 3 empty, then wrap to slot 1 (R2, R9, R12).
        press(2);
        check(slot_idx == 2'd2, "R2 advance to slot 3", slot_idx, 2);
        press(1);
        @(negedge clk);
        check(led == 1'b0, "R9 slot 3 empty", led, 0);
        press(2);
        check(slot_idx == 2'd0, "R2 wrap to slot 1", slot_idx, 0);
        play_check(0, 1'b0);

        // Slot 3 auto with the most negative sample (R8).
        press(2); press(2);
        check(slot_idx == 2'd2, "R2 back at slot 3", slot_idx, 2);
        auto_en = 1'b1;
        level_thr = 16'd32767;
        press(0);
        strobe(16'd32767);
        check(led == 1'b0, "R8 max positive equals threshold", led, 0);
        exp_data[2][0] = 16'h8000;
        strobe(exp_data[2][0]);
        check(led == 1'b1, "R8 most negative exceeds threshold", led, 1);
        for (int i = 1; i < CAP; i++) begin
            exp_data[2][i] = 16'(16'hF000 | i);
            strobe(exp_data[2][i]);
        end
        auto_en = 1'b0;
        play_check(2, 1'b0);

        // R12: slot 2 still intact after other slots were recorded.
        press(2); press(2);
        check(slot_idx == 2'd1, "R2 slot 2 again", slot_idx, 1);
        play_check(1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule